// File: doc/BRIEF.md
# PCI Configuration Address/Data Bridge

This block turns host accesses on two small I/O ports into PCI configuration-space requests. One port holds a 32-bit configuration address register; the other is a data window of up to four bytes. When software writes a target address with the enable bit set and then touches the data window, the bridge splits the latched address into bus, device/function and register offset. It merges the data-port byte lane into that offset, limits the access length so it cannot pass the end of the 256-byte configuration space, and issues one request with byte enables to a downstream device port.

The host side uses a valid/ready handshake with a one-cycle response pulse. Only one request is in flight at a time. The downstream side answers with an acknowledge, together with a no-device flag when nothing lives at the decoded target. Read data is aligned down to bit 0, and bytes beyond the access are cleared. A read returns all ones when the enable bit is off, when the length code is not supported, or when no device answers.

Top module: `pcfg_bridge`

## Requirements
- R1: After reset the address register reads as 0 (enable off), `h_ready` is high, `d_req` is low and `h_rsp_valid` is low.
- R2: A write to the address port (`h_sel_data`=0) with `h_len`=4 replaces the whole register. A read of that port returns it unchanged. Address-port writes with any other length leave it unchanged.
- R3: With bit 31 of the address register clear, a data-window read completes with 0xFFFFFFFF and a data-window write completes, in both cases without raising `d_req`.
- R4: For a request, `d_bus` is address bits 23:16 and `d_devfn` is bits 15:8. The register offset is address bits 7:0 ORed with `h_lane`, and `d_dword` is that offset's bits 7:2.
- R5: `h_len` gives the byte count; only 1, 2 and 4 are valid. A data-window access with any other value completes without a request, and a read then returns 0xFFFFFFFF.
- R6: `d_len` equals the smaller of the requested length and (256 − offset). A 4-byte access at offset 0xFD goes out with `d_len`=3.
- R7: Byte enable `d_be[i]` is set for each byte lane i with offset[1:0] ≤ i < offset[1:0]+`d_len`, limited to lanes 0..3. `d_wdata` is `h_wdata` shifted left by 8×offset[1:0].
- R8: Read data is `d_rdata` shifted right by 8×offset[1:0]. The bytes at and above the number of enabled lanes are returned as zero.
- R9: An acknowledge with `d_nodev` set makes a read return 0xFFFFFFFF and makes a write complete with no further effect.
- R10: From acceptance until the response, `h_ready` is low. `d_req` stays high with stable fields until `d_ack`. `h_rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access valid |
| h_ready | output | 1 | Bridge idle, access accepted when valid |
| h_write | input | 1 | 1 = write, 0 = read |
| h_sel_data | input | 1 | 0 = address port, 1 = data window |
| h_lane | input | 2 | Low two bits of the data-port address |
| h_len | input | 3 | Access length in bytes |
| h_wdata | input | 32 | Host write data, lane 0 aligned |
| h_rsp_valid | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read result, valid with h_rsp_valid |
| d_req | output | 1 | Downstream configuration request |
| d_ack | input | 1 | Downstream completion |
| d_nodev | input | 1 | No target present, valid with d_ack |
| d_write | output | 1 | Request direction |
| d_bus | output | 8 | Bus number |
| d_devfn | output | 8 | Device/function number |
| d_dword | output | 6 | Dword index of the register offset |
| d_len | output | 3 | Clipped length in bytes |
| d_be | output | 4 | Byte enables within the dword |
| d_wdata | output | 32 | Write data placed in its byte lanes |
| d_rdata | input | 32 | Downstream read data, dword aligned |

## Verification
The bound checker watches, on every cycle, that a request only appears while the enable bit is set. It also checks that a request is held steady until acknowledged, that `h_ready` stays low while busy, that responses are single-cycle pulses, that enables are non-empty and no wider than the clipped length, and that the address register changes only on a full-width address-port write. The exact field values, including the length clip at the top of the space, the ORing of the lane into the offset, read alignment and zero fill, and the all-ones defaults, can only be shown by the bench's scenarios. The bench compares these against its own model for each access.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } pcfg_state_e;

  // Lengths the data window accepts
  function automatic logic len_supported(input logic [2:0] n);
    return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
  endfunction

endpackage

// File: rtl/pcfg_rst_sync.sv
module pcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/pcfg_areg.sv
module pcfg_areg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) q <= '0;
    else         q <= q_d;
  end

endmodule

// File: rtl/pcfg_decode.sv
module pcfg_decode #(
  parameter int DW        = 32,
  parameter int CFG_BYTES = 256,
  parameter int ID_W      = 8,
  localparam int LANES    = DW / 8,
  localparam int LW       = $clog2(LANES),
  localparam int LENW     = LW + 1,
  localparam int OFF_W    = $clog2(CFG_BYTES),
  localparam int DWORD_W  = OFF_W - LW
) (
  input  logic [DW-1:0]      areg,
  input  logic [LW-1:0]      lane,
  input  logic [LENW-1:0]    len,
  input  logic [DW-1:0]      wdata,
  output logic [ID_W-1:0]    bus,
  output logic [ID_W-1:0]    devfn,
  output logic [DWORD_W-1:0] dword,
  output logic [LW-1:0]      lo,
  output logic [LENW-1:0]    clip,
  output logic [LANES-1:0]   be,
  output logic [LENW-1:0]    nbytes,
  output logic [DW-1:0]      wdata_lane
);

  logic [OFF_W-1:0] off;
  logic [OFF_W:0]   room;

  assign bus   = areg[OFF_W+ID_W +: ID_W];
  assign devfn = areg[OFF_W +: ID_W];
  assign off   = areg[OFF_W-1:0] | {{(OFF_W-LW){1'b0}}, lane};
  assign dword = off[OFF_W-1:LW];
  assign lo    = off[LW-1:0];

  // Bytes left from the offset to the end of configuration space
  assign room  = (OFF_W+1)'(CFG_BYTES) - {1'b0, off};
  assign clip  = ((OFF_W+1)'(len) < room) ? len : LENW'(room);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      be[i] = (i >= int'(lo)) && (i < int'(lo) + int'(clip));
    end
  end

  always_comb begin
    nbytes = '0;
    for (int i = 0; i < LANES; i++) begin
      nbytes = nbytes + LENW'(be[i]);
    end
  end

  assign wdata_lane = wdata << {lo, 3'b000};

endmodule

// File: rtl/pcfg_rdfmt.sv
module pcfg_rdfmt #(
  parameter int DW     = 32,
  localparam int LANES = DW / 8,
  localparam int LW    = $clog2(LANES),
  localparam int LENW  = LW + 1
) (
  input  logic [DW-1:0]   raw,
  input  logic [LW-1:0]   lo,
  input  logic [LENW-1:0] nbytes,
  output logic [DW-1:0]   fmt
);

  logic [DW-1:0] shifted;

  assign shifted = raw >> {lo, 3'b000};

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    assign fmt[8*j +: 8] = (j < int'(nbytes)) ? shifted[8*j +: 8] : 8'h00;
  end

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
  import pcfg_pkg::*;
#(
  parameter int DW     = 32,
  localparam int LANES = DW / 8,
  localparam int LW    = $clog2(LANES),
  localparam int LENW  = LW + 1
) (
  input  logic            clk,
  input  logic            rst_ns,
  input  logic            h_valid,
  output logic            h_ready,
  input  logic            h_write,
  input  logic            h_sel_data,
  input  logic [LW-1:0]   h_lane,
  input  logic [LENW-1:0] h_len,
  input  logic [DW-1:0]   h_wdata,
  output logic            h_rsp_valid,
  output logic [DW-1:0]   h_rdata,
  input  logic [DW-1:0]   areg,
  input  logic [DW-1:0]   fmt_rdata,
  output logic            areg_we,
  output logic            req,
  output logic            wr,
  output logic [LW-1:0]   lane,
  output logic [LENW-1:0] len,
  output logic [DW-1:0]   wdata,
  input  logic            d_ack,
  input  logic            d_nodev
);

  pcfg_state_e    st_q, st_d;
  logic           wr_d;
  logic [LW-1:0]  lane_d;
  logic [LENW-1:0] len_d;
  logic [DW-1:0]  wdata_d, rsp_q, rsp_d;
  logic           accept, cap_en, rsp_en;

  assign accept  = h_valid && (st_q == ST_IDLE);
  assign areg_we = accept && h_write && !h_sel_data && (h_len == LENW'(LANES));

  always_comb begin
    st_d    = st_q;
    rsp_d   = rsp_q;
    rsp_en  = 1'b0;
    cap_en  = 1'b0;
    wr_d    = h_write;
    lane_d  = h_lane;
    len_d   = h_len;
    wdata_d = h_wdata;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        cap_en = 1'b1;
        rsp_en = 1'b1;
        if (!h_sel_data) begin
          rsp_d = h_write ? '0 : areg;
          st_d  = ST_RESP;
        end else if (!areg[DW-1] || !len_supported(h_len)) begin
          rsp_d = h_write ? '0 : '1;
          st_d  = ST_RESP;
        end else begin
          rsp_d = '0;
          st_d  = ST_ISSUE;
        end
      end
      ST_ISSUE: if (d_ack) begin
        rsp_en = 1'b1;
        rsp_d  = wr ? '0 : (d_nodev ? '1 : fmt_rdata);
        st_d   = ST_RESP;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q  <= ST_IDLE;
      rsp_q <= '0;
      wr    <= 1'b0;
      lane  <= '0;
      len   <= '0;
      wdata <= '0;
    end else begin
      st_q <= st_d;
      if (rsp_en) rsp_q <= rsp_d;
      if (cap_en) begin
        wr    <= wr_d;
        lane  <= lane_d;
        len   <= len_d;
        wdata <= wdata_d;
      end
    end
  end

  assign h_ready     = (st_q == ST_IDLE);
  assign h_rsp_valid = (st_q == ST_RESP);
  assign h_rdata     = rsp_q;
  assign req         = (st_q == ST_ISSUE);

endmodule

// File: rtl/pcfg_bridge.sv
module pcfg_bridge #(
  parameter int DW        = 32,
  parameter int CFG_BYTES = 256,
  parameter int ID_W      = 8,
  localparam int LANES    = DW / 8,
  localparam int LW       = $clog2(LANES),
  localparam int LENW     = LW + 1,
  localparam int OFF_W    = $clog2(CFG_BYTES),
  localparam int DWORD_W  = OFF_W - LW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_valid,
  output logic               h_ready,
  input  logic               h_write,
  input  logic               h_sel_data,
  input  logic [LW-1:0]      h_lane,
  input  logic [LENW-1:0]    h_len,
  input  logic [DW-1:0]      h_wdata,
  output logic               h_rsp_valid,
  output logic [DW-1:0]      h_rdata,
  output logic               d_req,
  input  logic               d_ack,
  input  logic               d_nodev,
  output logic               d_write,
  output logic [ID_W-1:0]    d_bus,
  output logic [ID_W-1:0]    d_devfn,
  output logic [DWORD_W-1:0] d_dword,
  output logic [LENW-1:0]    d_len,
  output logic [LANES-1:0]   d_be,
  output logic [DW-1:0]      d_wdata,
  input  logic [DW-1:0]      d_rdata
);

  logic            rst_ns;
  logic [DW-1:0]   addr_q;
  logic            areg_we;
  logic [LW-1:0]   cap_lane, lo;
  logic [LENW-1:0] cap_len, nbytes;
  logic [DW-1:0]   cap_wdata, fmt_rdata;

  pcfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  pcfg_areg #(.DW(DW)) u_areg (
    .clk(clk), .rst_ns(rst_ns), .we(areg_we), .wdata(h_wdata), .q(addr_q)
  );

  pcfg_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_ns(rst_ns),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_sel_data(h_sel_data), .h_lane(h_lane), .h_len(h_len),
    .h_wdata(h_wdata), .h_rsp_valid(h_rsp_valid), .h_rdata(h_rdata),
    .areg(addr_q), .fmt_rdata(fmt_rdata), .areg_we(areg_we),
    .req(d_req), .wr(d_write), .lane(cap_lane), .len(cap_len),
    .wdata(cap_wdata), .d_ack(d_ack), .d_nodev(d_nodev)
  );

  pcfg_decode #(.DW(DW), .CFG_BYTES(CFG_BYTES), .ID_W(ID_W)) u_dec (
    .areg(addr_q), .lane(cap_lane), .len(cap_len), .wdata(cap_wdata),
    .bus(d_bus), .devfn(d_devfn), .dword(d_dword), .lo(lo),
    .clip(d_len), .be(d_be), .nbytes(nbytes), .wdata_lane(d_wdata)
  );

  pcfg_rdfmt #(.DW(DW)) u_fmt (
    .raw(d_rdata), .lo(lo), .nbytes(nbytes), .fmt(fmt_rdata)
  );

endmodule

// File: rtl/pcfg_bridge_chk.sv
module pcfg_bridge_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          h_valid,
  input logic          h_ready,
  input logic          h_write,
  input logic          h_sel_data,
  input logic [2:0]    h_len,
  input logic          h_rsp_valid,
  input logic          d_req,
  input logic          d_ack,
  input logic [2:0]    d_len,
  input logic [3:0]    d_be,
  input logic [7:0]    d_bus,
  input logic [5:0]    d_dword,
  input logic [DW-1:0] addr_q
);

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    d_req |-> addr_q[DW-1]);  // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_ns)
    d_req |-> !h_ready);  // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (d_req && !d_ack) |=> (d_req && $stable(d_be) && $stable(d_bus) && $stable(d_dword)));  // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    h_rsp_valid |=> (!h_rsp_valid && h_ready));  // R10

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_ns)
    d_req |-> (d_be != 4'd0 && $countones(d_be) <= int'(d_len)));  // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_ns)
    d_req |-> (d_len != 3'd0 && d_len <= 3'd4));  // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !(h_valid && h_ready && h_write && !h_sel_data && h_len == 3'd4) |=> $stable(addr_q));  // R2

endmodule

bind pcfg_bridge pcfg_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .h_valid(h_valid), .h_ready(h_ready),
  .h_write(h_write), .h_sel_data(h_sel_data), .h_len(h_len),
  .h_rsp_valid(h_rsp_valid), .d_req(d_req), .d_ack(d_ack), .d_len(d_len),
  .d_be(d_be), .d_bus(d_bus), .d_dword(d_dword), .addr_q(addr_q)
);

// File: tb/pcfg_bridge_test.sv
module pcfg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_valid, h_write, h_sel_data;
  logic [1:0]  h_lane;
  logic [2:0]  h_len;
  logic [31:0] h_wdata;
  logic        h_ready, h_rsp_valid;
  logic [31:0] h_rdata;
  logic        d_req, d_ack, d_nodev, d_write;
  logic [7:0]  d_bus, d_devfn;
  logic [5:0]  d_dword;
  logic [2:0]  d_len;
  logic [3:0]  d_be;
  logic [31:0] d_wdata, d_rdata;

  int total = 0;
  int failed = 0;

  always #5 clk = ~clk;

  pcfg_bridge uut (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready),
    .h_write(h_write), .h_sel_data(h_sel_data), .h_lane(h_lane),
    .h_len(h_len), .h_wdata(h_wdata), .h_rsp_valid(h_rsp_valid),
    .h_rdata(h_rdata), .d_req(d_req), .d_ack(d_ack), .d_nodev(d_nodev),
    .d_write(d_write), .d_bus(d_bus), .d_devfn(d_devfn), .d_dword(d_dword),
    .d_len(d_len), .d_be(d_be), .d_wdata(d_wdata), .d_rdata(d_rdata)
  );

  // Captured downstream request and host response
  logic        got_req, hung;
  logic        c_write;
  logic [7:0]  c_bus, c_devfn;
  logic [5:0]  c_dword;
  logic [2:0]  c_len;
  logic [3:0]  c_be;
  logic [31:0] c_wdata, rsp;
  logic [31:0] m_addr;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_off(input logic [31:0] a, input logic [1:0] ln);
    return a[7:0] | {6'd0, ln};
  endfunction

  function automatic logic [2:0] e_clip(input logic [7:0] off, input logic [2:0] len);
    int room = 256 - int'(off);
    return (int'(len) < room) ? len : 3'(room);
  endfunction

  function automatic logic [3:0] e_be(input logic [1:0] lo, input logic [2:0] n);
    logic [3:0] b = '0;
    for (int i = 0; i < 4; i++) b[i] = (i >= int'(lo)) && (i < int'(lo) + int'(n));
    return b;
  endfunction

  function automatic logic [31:0] e_fmt(input logic [31:0] raw, input logic [1:0] lo, input logic [3:0] be);
    logic [31:0] s = raw >> (8 * int'(lo));
    logic [31:0] r = '0;
    int nb = $countones(be);
    for (int j = 0; j < 4; j++) if (j < nb) r[8*j +: 8] = s[8*j +: 8];
    return r;
  endfunction

  task automatic xfer(input logic wr, input logic sel, input logic [1:0] ln, input logic [2:0] len,
                      input logic [31:0] wd, input logic nd, input logic [31:0] drd);
    int cyc;
    got_req = 1'b0;
    hung = 1'b0;
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_sel_data = sel; h_lane = ln; h_len = len; h_wdata = wd;
    @(negedge clk);
    h_valid = 1'b0;
    cyc = 0;
    while (!h_rsp_valid && cyc < 20) begin
      if (h_ready) hung = 1'b1;  // R10: ready must stay low while busy
      if (d_req && !d_ack) begin
        got_req = 1'b1;
        c_write = d_write; c_bus = d_bus; c_devfn = d_devfn; c_dword = d_dword;
        c_len = d_len; c_be = d_be; c_wdata = d_wdata;
        d_ack = 1'b1; d_nodev = nd; d_rdata = drd;
      end else begin
        d_ack = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    d_ack = 1'b0; d_nodev = 1'b0;
    rsp = h_rdata;
    check(h_rsp_valid && !hung, "R10 handshake", {31'd0, h_rsp_valid}, 32'd1);
  endtask

  task automatic areg_wr(input logic [31:0] v, input logic [2:0] len);
    xfer(1'b1, 1'b0, 2'd0, len, v, 1'b0, 32'd0);
    if (len == 3'd4) m_addr = v;
  endtask

  task automatic areg_rd();
    xfer(1'b0, 1'b0, 2'd0, 3'd4, 32'd0, 1'b0, 32'd0);
    check(rsp == m_addr && !got_req, "R2 address readback", rsp, m_addr);
  endtask

  task automatic data_op(input logic wr, input logic [1:0] ln, input logic [2:0] len,
                         input logic [31:0] wd, input logic nd, input logic [31:0] drd);
    logic [7:0]  off = e_off(m_addr, ln);
    logic [2:0]  cl  = e_clip(off, len);
    logic [3:0]  be  = e_be(off[1:0], cl);
    logic        ok  = (len == 3'd1 || len == 3'd2 || len == 3'd4);
    xfer(wr, 1'b1, ln, len, wd, nd, drd);
    if (!m_addr[31]) begin
      check(!got_req, "R3 no request when disabled", {31'd0, got_req}, 32'd0);
      if (!wr) check(rsp == 32'hFFFF_FFFF, "R3 disabled read all ones", rsp, 32'hFFFF_FFFF);
    end else if (!ok) begin
      check(!got_req, "R5 bad length no request", {31'd0, got_req}, 32'd0);
      if (!wr) check(rsp == 32'hFFFF_FFFF, "R5 bad length read all ones", rsp, 32'hFFFF_FFFF);
    end else begin
      check(got_req && c_write == wr, "R10 request issued", {31'd0, got_req}, 32'd1);
      check(c_bus == m_addr[23:16] && c_devfn == m_addr[15:8], "R4 bus/devfn",
            {16'd0, c_bus, c_devfn}, {16'd0, m_addr[23:16], m_addr[15:8]});
      check(c_dword == off[7:2], "R4 dword index", {26'd0, c_dword}, {26'd0, off[7:2]});
      check(c_len == cl, "R6 clipped length", {29'd0, c_len}, {29'd0, cl});
      check(c_be == be, "R7 byte enables", {28'd0, c_be}, {28'd0, be});
      if (wr) check(c_wdata == (wd << (8 * int'(off[1:0]))), "R7 write lanes", c_wdata,
                    wd << (8 * int'(off[1:0])));
      if (!wr && nd) check(rsp == 32'hFFFF_FFFF, "R9 no device read", rsp, 32'hFFFF_FFFF);
      if (!wr && !nd) check(rsp == e_fmt(drd, off[1:0], be), "R8 read alignment", rsp,
                            e_fmt(drd, off[1:0], be));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; h_valid = 1'b0; h_write = 1'b0; h_sel_data = 1'b0; h_lane = '0;
    h_len = '0; h_wdata = '0; d_ack = 1'b0; d_nodev = 1'b0; d_rdata = '0;
    m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(h_ready && !d_req && !h_rsp_valid, "R1 idle after reset",
          {29'd0, h_ready, d_req, h_rsp_valid}, 32'd4);
    areg_rd();  // R1 register clear

    // R3 disabled window
    data_op(1'b0, 2'd0, 3'd4, 32'd0, 1'b0, 32'h1234_5678);
    data_op(1'b1, 2'd1, 3'd1, 32'hAB, 1'b0, 32'd0);

    // R2 full write, then short writes ignored
    areg_wr(32'h8012_3404, 3'd4);
    areg_rd();
    areg_wr(32'h0000_00FF, 3'd1);
    areg_wr(32'h0000_FFFF, 3'd2);
    areg_rd();

    // R6 clip at top of space: offset 0xFD, 4 bytes -> 3
    areg_wr(32'h8001_08FC, 3'd4);
    data_op(1'b0, 2'd1, 3'd4, 32'd0, 1'b0, 32'hDDCC_BBAA);
    data_op(1'b1, 2'd1, 3'd4, 32'h0033_2211, 1'b0, 32'd0);
    data_op(1'b0, 2'd3, 3'd2, 32'd0, 1'b0, 32'h4433_2211);
    // R4 lane ORed with latched low bits
    areg_wr(32'h8005_2A41, 3'd4);
    data_op(1'b0, 2'd2, 3'd1, 32'd0, 1'b0, 32'h8877_6655);
    // R5 unsupported length codes
    data_op(1'b0, 2'd0, 3'd3, 32'd0, 1'b0, 32'd0);
    data_op(1'b1, 2'd0, 3'd0, 32'd1, 1'b0, 32'd0);
    // R9 no device
    data_op(1'b0, 2'd0, 3'd4, 32'd0, 1'b1, 32'h0);
    data_op(1'b1, 2'd2, 3'd2, 32'hBEEF, 1'b1, 32'h0);

    for (int n = 0; n < 400; n++) begin
      int pick = $urandom_range(99);
      if (pick < 15) begin
        logic [31:0] v = $urandom();
        v[31] = ($urandom_range(9) != 0);
        if ($urandom_range(3) == 0) v[7:2] = 6'h3F;
        areg_wr(v, 3'd4);
      end else if (pick < 20) begin
        areg_wr($urandom(), ($urandom_range(1) != 0) ? 3'd1 : 3'd2);
      end else if (pick < 25) begin
        areg_rd();
      end else begin
        int lp = $urandom_range(9);
        logic [2:0] len = (lp < 3) ? 3'd1 : (lp < 6) ? 3'd2 : (lp < 9) ? 3'd4 : 3'($urandom_range(7));
        data_op(1'($urandom_range(1)), 2'($urandom_range(3)), len, $urandom(),
                ($urandom_range(6) == 0), $urandom());
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule